// File: doc/BRIEF.md
# Programmable Clock Divider with Single-Pulse Phase Slip

The block divides a fast input clock by an integer modulus and produces a slower divided clock. Software can move the phase of the divided clock later by one input period at a time. It does this by toggling a phase-step bit. Each rising transition of that bit deletes exactly one input edge before it reaches the divide counter, so the counter loses one count and the whole output waveform moves back by one input period. The design is fully synchronous. The deletion works as a count enable on the counter, not as a gated clock.

Odd moduli still give a nominal 50/50 duty cycle. A copy of the counter's high flag, retimed on the falling edge, stretches the high time by half an input period. A feedback tap output reports, for every input cycle, whether the next input edge reaches the divider. A select input chooses between that gated view and the plain undivided clock. While the phase is being stepped, the gated view is the one to use.

Top module: `pulse_slip_divider`

## Requirements
- R1: For an even modulus P, the divided clock has a period of exactly P input cycles. It is high for the first P/2 cycles of each period, counting from the count-zero cycle, and low for the rest.
- R2: For an odd modulus P of 3 or more, the divided clock is high for (P-1)/2 whole input cycles plus the first half of the next cycle. It is low for the remainder of the period.
- R3: Each 0-to-1 transition of `step_req` deletes exactly one input edge from the divider. Every later output transition therefore moves one input period later. Holding `step_req` high deletes no further edges.
- R4: Let edge k be the first rising edge of `clk_in` at which `step_req` is sampled high after having been sampled low. The edge that is deleted is edge k+2.
- R5: With `fb_sel` = 0, `fb_tap` is 1 in every cycle. With `fb_sel` = 1, `fb_tap` is 0 during exactly the cycle that ends with a deleted edge, and 1 otherwise.
- R6: A new value on `modulus` takes effect only at the edge where the counter wraps from P-1 to 0. The period in progress keeps its old length.
- R7: For a modulus of 1, the divided clock is high in the first half and low in the second half of each input cycle. It is low for the whole cycle that follows a deleted edge. A modulus of 0 behaves exactly like 1.
- R8: `rst_n` is synchronous and active low. While it is low, the counter holds at zero with the current modulus loaded, and any step already in the synchronizer is discarded. The first edge after release advances the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| modulus | input | MOD_W | Divide modulus P (0 is treated as 1) |
| step_req | input | 1 | Phase-step bit; each rising transition deletes one input edge |
| fb_sel | input | 1 | Feedback tap select: 0 = undivided clock, 1 = divider input after deletion |
| clk_div | output | 1 | Divided output clock |
| fb_tap | output | 1 | Per-cycle feedback tap: 1 when the next input edge reaches the selected point |

## Verification
The divided clock changes right after each rising edge that advances the counter. The odd-modulus stretch and the modulus-1 low half only appear after the following falling edge. The bench therefore samples every cycle twice: once inside the high half and once inside the low half. A step bit driven in one cycle is captured at the next edge, and the deletion lands two edges after that capture. `fb_tap` drops during the cycle just before the deleted edge. The cycle model in the bench keeps a history of captured step samples and compares against these exact delays in every cycle. A new modulus is checked only against the model's wrap point. The single cycle in which reset is first asserted is left out of the output comparison, because the retimed flops still hold their values from before reset.

// File: rtl/pulse_slip_divider.sv
`timescale 1ns/1ps
module pulse_slip_divider #(
  parameter int MOD_W = 6
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] modulus,
  input  logic             step_req,
  input  logic             fb_sel,
  output logic             clk_div,
  output logic             fb_tap
);
  localparam logic [MOD_W-1:0] ONE = MOD_W'(1);

  logic [2:0]       sync_q;
  logic [MOD_W-1:0] cnt, cur_p, next_p;
  logic             tgl, tgl_f, hi_r, hi_f;
  logic             slip, adv, wrap;

  assign slip   = sync_q[1] & ~sync_q[2];
  assign adv    = ~slip;
  assign next_p = (modulus == '0) ? ONE : modulus;
  assign wrap   = (cnt == cur_p - ONE);
  assign hi_r   = (cnt < (cur_p >> 1));

  always_ff @(posedge clk_in) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt    <= '0;
      cur_p  <= next_p;
      tgl    <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], step_req};
      if (adv) begin
        tgl <= ~tgl;
        if (wrap) begin
          cnt   <= '0;
          cur_p <= next_p;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  always_ff @(negedge clk_in) begin
    if (!rst_n) begin
      hi_f  <= 1'b0;
      tgl_f <= 1'b0;
    end else begin
      hi_f  <= hi_r;
      tgl_f <= tgl;
    end
  end

  assign clk_div = (cur_p == ONE) ? (tgl ^ tgl_f) :
                   cur_p[0]       ? (hi_r | hi_f) : hi_r;
  assign fb_tap  = ~fb_sel | adv;
endmodule

module pulse_slip_divider_chk #(
  parameter int MOD_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slip,
  input logic [MOD_W-1:0] cnt,
  input logic [MOD_W-1:0] cur_p
);
  // R3
  slip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !slip);
  // R3
  slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> $stable(cnt));
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_p);
  // R6
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip || cnt != cur_p - MOD_W'(1)) |=> $stable(cur_p));
  // R7
  mod_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_p != '0);
  // R8
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt == '0 && !slip));
endmodule

bind pulse_slip_divider pulse_slip_divider_chk #(.MOD_W(MOD_W)) chk_i (
  .clk(clk_in), .rst_n(rst_n), .slip(slip), .cnt(cnt), .cur_p(cur_p)
);

// File: tb/pulse_slip_divider_tb_top.sv
`timescale 1ns/1ps
module pulse_slip_divider_tb_top;
  localparam int MOD_W = 6;
  localparam int WD_CYCLES = 200000;

  logic clk_in = 1'b0;
  logic rst_n = 1'b0;
  logic [MOD_W-1:0] modulus = MOD_W'(4);
  logic step_req = 1'b0;
  logic fb_sel = 1'b0;
  logic clk_div, fb_tap;

  pulse_slip_divider #(.MOD_W(MOD_W)) dut_i (
    .clk_in(clk_in), .rst_n(rst_n), .modulus(modulus), .step_req(step_req),
    .fb_sel(fb_sel), .clk_div(clk_div), .fb_tap(fb_tap)
  );

  always #2.5 clk_in = ~clk_in;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R8";

  logic d_rst = 1'b0, d_step = 1'b0, d_sel = 1'b0;
  int d_mod = 4;

  int samp[$] = '{0, 0, 0, 0};
  int cnt_m = 0, p_m = 4;
  bit hr_m = 0, hrprev_m = 0, en_m = 0, rst_prev = 0, skip_out = 0;

  function automatic int eff(int m);
    return (m == 0) ? 1 : m;
  endfunction

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: got %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  task automatic model_edge();
    hrprev_m = rst_n ? hr_m : 1'b0;
    skip_out = rst_prev && !rst_n;
    if (!rst_n) begin
      samp = '{0, 0, 0, 0};
      cnt_m = 0;
      p_m = eff(int'(modulus));
      en_m = 0;
    end else begin
      samp.push_front(int'(step_req));
      void'(samp.pop_back());
      en_m = !(samp[2] == 1 && samp[3] == 0);
      if (en_m) begin
        if (cnt_m == p_m - 1) begin
          cnt_m = 0;
          p_m = eff(int'(modulus));
        end else cnt_m++;
      end
    end
    rst_prev = rst_n;
    hr_m = (cnt_m < p_m / 2);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      logic e_hi, e_lo, e_fb;
      @(posedge clk_in);
      #1;
      model_edge();
      rst_n = d_rst; step_req = d_step; fb_sel = d_sel; modulus = MOD_W'(d_mod);
      e_hi = (p_m == 1) ? en_m : ((p_m % 2 == 1) ? (hr_m | hrprev_m) : hr_m);
      e_lo = (p_m == 1) ? 1'b0 : hr_m;
      e_fb = !fb_sel || !(samp[1] == 1 && samp[2] == 0);
      #0.5;
      if (!skip_out) chk("clk_div high half", clk_div, e_hi);
      chk("fb_tap", fb_tap, e_fb);
      #2.5;
      if (!skip_out) chk("clk_div low half", clk_div, e_lo);
    end
  endtask

  task automatic step_pulse(int high_cycles, int low_cycles);
    d_step = 1; run(high_cycles);
    d_step = 0; run(low_cycles);
  endtask

  initial begin
    // R8 reset state: counter at zero with modulus loaded
    tag = "R8"; d_rst = 0; d_mod = 4; run(4);
    d_rst = 1; run(2);
    // R1 even moduli
    tag = "R1"; run(20);
    d_mod = 6; run(30);
    // R2 odd moduli
    tag = "R2"; d_mod = 5; run(25);
    d_mod = 3; run(18);
    d_mod = 7; run(30);
    // R3 held step bit deletes one edge only
    tag = "R3"; d_mod = 4; run(8);
    step_pulse(12, 6);
    step_pulse(3, 9);
    // R4 one-cycle step pulse, latency to the deleted edge
    tag = "R4"; d_mod = 6; step_pulse(1, 10);
    d_mod = 5; step_pulse(1, 2); step_pulse(1, 12);
    // R5 feedback tap in both selections with steps
    tag = "R5"; d_sel = 1; step_pulse(2, 8); step_pulse(1, 8);
    d_sel = 0; step_pulse(2, 8);
    d_sel = 1;
    // R6 modulus change mid-period
    tag = "R6"; d_mod = 8; run(19);
    d_mod = 3; run(14);
    d_mod = 10; run(1);
    d_mod = 2; run(16);
    // R7 pass-through modulus and zero modulus
    tag = "R7"; d_mod = 1; run(6);
    step_pulse(2, 6);
    d_mod = 0; run(6);
    step_pulse(1, 6);
    d_mod = 4; run(10);
    // R8 reset while a step is pending in the synchronizer
    tag = "R8"; d_step = 1; run(1);
    d_rst = 0; d_step = 0; run(3);
    d_rst = 1; d_mod = 5; run(20);
    d_step = 1; run(2);
    d_rst = 0; run(2);
    d_rst = 1; run(15);
    d_step = 0; run(10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(WD_CYCLES * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule